// File: doc/BRIEF.md
# BCD Real-Time Clock with Byte Storage

This block is a byte-addressed store with a calendar clock placed in the last eight bytes of its address window. A host reaches it over a simple synchronous bus that carries an address, write data, a write strobe and a read strobe. Read data comes back in the cycle after the read strobe and holds until the next read. The clock keeps seconds, minutes, hours, weekday, date, month and year in packed BCD, with the tens digit in the upper nibble. It moves forward on a one-pulse-per-second enable input.

Every clock field write is masked to its field width and range-checked, and a value outside the range is dropped without a trace. A stop bit in the seconds byte freezes timekeeping. Two lock bits each guard a sixteen-byte stretch of the store. A build-time option decides what the eight bytes just below the clock registers are: either reserved locations, or extra plain storage for the smaller variant.

Top module: `bcd_rtc_nvram`

## Requirements
- R1: Reset clears the stop bit and both lock bits, sets the clock to 00:00:00 with weekday 1, date 01, month 01, year 00 and century flag 0, and sets the control byte to 0x90. It leaves the byte store contents unchanged.
- R2: An address below MEM_BYTES that is not locked is plain storage. A byte written there reads back unchanged, and read data appears in the cycle after the read strobe.
- R3: An address from MEM_BYTES up to the start of the top sixteen-byte window reads as 0xFF, and writes there change nothing.
- R4: The control byte sits at offset 0 of the clock block (top address minus 7). A write stores the data with bits 7 and 5 cleared and then bits 7 and 4 set.
- R5: Offset 1 (seconds) bit 7 is the stop bit. A seconds write always updates it. While it is set, ticks do not change the time. After it is cleared, counting resumes from the frozen value. A seconds read returns the stop bit in bit 7 and the BCD seconds in bits 6:0.
- R6: Field writes take only the field bits and accept only valid BCD digits within range; any other value leaves the field unchanged. Seconds (offset 1) and minutes (offset 2) use bits 6:0 with range 00–59. Hours (offset 3) use bits 5:0 with range 00–23. Date (offset 5) uses bits 4:0 and must be nonzero. Month (offset 6) uses bits 4:0 with range 01–12. Year (offset 7) uses bits 7:0 with range 00–99.
- R7: A tick while not stopped advances seconds in BCD. Seconds carry from 59 into minutes, minutes carry from 59 into hours, and hours carry from 23 into the day.
- R8: A day carry advances the date, wrapping to 01 after the last day of the month: 30 days for months 04, 06, 09 and 11, and 28 days for month 02, or 29 when the BCD year is divisible by 4. Month wraps from 12 to 01 with a year carry, and year wraps from 99 to 00.
- R9: Offset 4 holds the weekday in bits 2:0 and a stored century flag in bit 6, and both are written without checks. A read returns {0, century, 000, weekday}. A day carry moves the weekday from 7 to 1 and otherwise adds one.
- R10: While lock bit 0 is set, addresses 0x20–0x2F drop writes and read 0xFF. Lock bit 1 does the same for 0x30–0x3F. The lock bits load from lock_din when lock_load is high.
- R11: With WINDOW_AS_RAM=0, the eight bytes just below the clock block ignore writes and read 0x00. With WINDOW_AS_RAM=1 they are plain storage.
- R12: A valid field write that arrives in the same cycle as a tick loads the written value, and that field ignores the tick. The other fields still advance normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second of timekeeping |
| addr | input | ADDR_W | Byte address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| lock_load | input | 1 | Loads the lock bits |
| lock_din | input | 2 | New lock bits, bit g guards region g |

## Verification
A corrupted counter or carry term does not show up until the host reads a field. It then appears one cycle after the read strobe, either as a wrong BCD value in the field itself or in the neighbouring field that should have taken the carry. The bench therefore drives each carry path, including every kind of month end and the year wrap, and reads all affected fields straight after the tick. A wrong lock or decode state shows up as 0xFF, or as stale data, on the next read of the address it hides. Because of that, every lock and window case is paired with a read before and a read after the change.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   localparam int unsigned LOCK_BASE    = 32;
   localparam int unsigned LOCK_SPAN    = 16;
   localparam int unsigned LOCK_REGIONS = 2;

   typedef enum logic [2:0] {
      RG_RAM, RG_LOCKED, RG_VOID, RG_CLOCK, RG_WINRAM, RG_WINRSV
   } region_e;

   // field order follows the low three address bits of the clock block
   typedef enum logic [2:0] {
      F_CTRL = 3'd0, F_SEC = 3'd1, F_MIN = 3'd2, F_HOUR = 3'd3,
      F_WDAY = 3'd4, F_DATE = 3'd5, F_MON = 3'd6, F_YEAR = 3'd7
   } field_e;

   function automatic logic bcd_ok(input logic [7:0] v);
      return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9);
   endfunction

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return v + 8'd1;
   endfunction

   // BCD year divisible by four: even tens with units 0/4/8, odd tens with 2/6
   function automatic logic is_leap(input logic [7:0] y);
      if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
      else       return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
   endfunction

   function automatic logic [5:0] month_len(input logic [4:0] m, input logic leap);
      case (m)
         5'h02:                      return leap ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
         default:                    return 6'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_addr_dec.sv
module rtc_addr_dec
   import rtc_pkg::*;
#(
   parameter int unsigned ADDR_W        = 13,
   parameter int unsigned MEM_BYTES     = 512,
   parameter bit          WINDOW_AS_RAM = 1'b0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        lock,
   output region_e           region
);
   localparam logic [ADDR_W:0] MEM_TOP = (ADDR_W+1)'(MEM_BYTES);

   logic [LOCK_REGIONS-1:0] lk_hit;
   region_e                 win_kind;

   for (genvar g = 0; g < LOCK_REGIONS; g++) begin : g_lock
      localparam logic [ADDR_W-1:0] LO = ADDR_W'(LOCK_BASE + g * LOCK_SPAN);
      localparam logic [ADDR_W-1:0] HI = ADDR_W'(LOCK_BASE + (g + 1) * LOCK_SPAN);
      assign lk_hit[g] = lock[g] && (addr >= LO) && (addr < HI);
   end

   if (WINDOW_AS_RAM) begin : g_win_ram
      assign win_kind = RG_WINRAM;
   end else begin : g_win_rsv
      assign win_kind = RG_WINRSV;
   end

   always_comb begin
      if (&addr[ADDR_W-1:4])         region = addr[3] ? RG_CLOCK : win_kind;
      else if (|lk_hit)              region = RG_LOCKED;
      else if ({1'b0, addr} < MEM_TOP) region = RG_RAM;
      else                           region = RG_VOID;
   end
endmodule

// File: rtl/rtc_byte_store.sv
module rtc_byte_store #(
   parameter int unsigned DEPTH = 512,
   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             we,
   input  logic             re,
   input  logic [IDX_W-1:0] idx,
   input  logic [7:0]       wd,
   output logic [7:0]       rq
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= wd;
      if (re) rq <= mem[idx];
   end
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
   import rtc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       we,
   input  logic [2:0] fsel,
   input  logic [7:0] wd,
   output logic [7:0] rd,
   output logic       stop_o,
   output logic [6:0] sec_o
);
   logic [7:0] ctrl_q, ctrl_n;
   logic [6:0] sec_q, sec_n, min_q, min_n;
   logic [5:0] hour_q, hour_n, date_q, date_n;
   logic [2:0] wday_q, wday_n;
   logic [4:0] mon_q, mon_n;
   logic [7:0] year_q, year_n;
   logic       cent_q, cent_n, stop_q, stop_n;

   logic       adv, roll_m, roll_h, roll_d, roll_mo, roll_y;
   logic [5:0] mlen;
   field_e     fld;

   assign fld = field_e'(fsel);

   always_comb begin
      adv     = tick && !stop_q;
      mlen    = month_len(mon_q, is_leap(year_q));
      roll_m  = adv && (sec_q == 7'h59);
      roll_h  = roll_m && (min_q == 7'h59);
      roll_d  = roll_h && (hour_q == 6'h23);
      roll_mo = roll_d && (date_q >= mlen);
      roll_y  = roll_mo && (mon_q == 5'h12);

      // counting
      sec_n  = !adv    ? sec_q  : (roll_m  ? 7'h00 : 7'(bcd_inc({1'b0, sec_q})));
      min_n  = !roll_m ? min_q  : (roll_h  ? 7'h00 : 7'(bcd_inc({1'b0, min_q})));
      hour_n = !roll_h ? hour_q : (roll_d  ? 6'h00 : 6'(bcd_inc({2'b0, hour_q})));
      date_n = !roll_d ? date_q : (roll_mo ? 6'h01 : 6'(bcd_inc({2'b0, date_q})));
      wday_n = !roll_d ? wday_q : ((wday_q == 3'd7) ? 3'd1 : wday_q + 3'd1);
      mon_n  = !roll_mo ? mon_q : (roll_y  ? 5'h01 : 5'(bcd_inc({3'b0, mon_q})));
      year_n = !roll_y ? year_q : ((year_q == 8'h99) ? 8'h00 : bcd_inc(year_q));
      ctrl_n = ctrl_q;
      cent_n = cent_q;
      stop_n = stop_q;

      // host writes override the written field only
      if (we) begin
         case (fld)
            F_CTRL: ctrl_n = (wd & ~8'hA0) | 8'h90;
            F_SEC: begin
               stop_n = wd[7];
               if (bcd_ok({1'b0, wd[6:0]}) && (wd[6:0] <= 7'h59)) sec_n = wd[6:0];
            end
            F_MIN:
               if (bcd_ok({1'b0, wd[6:0]}) && (wd[6:0] <= 7'h59)) min_n = wd[6:0];
            F_HOUR:
               if (bcd_ok({2'b0, wd[5:0]}) && (wd[5:0] <= 6'h23)) hour_n = wd[5:0];
            F_WDAY: begin
               wday_n = wd[2:0];
               cent_n = wd[6];
            end
            F_DATE:
               if (bcd_ok({3'b0, wd[4:0]}) && (wd[4:0] != 5'h00)) date_n = {1'b0, wd[4:0]};
            F_MON:
               if (bcd_ok({3'b0, wd[4:0]}) && (wd[4:0] != 5'h00) && (wd[4:0] <= 5'h12))
                  mon_n = wd[4:0];
            F_YEAR:
               if (bcd_ok(wd) && (wd <= 8'h99)) year_n = wd;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= 8'h90;
         sec_q  <= 7'h00;
         min_q  <= 7'h00;
         hour_q <= 6'h00;
         wday_q <= 3'd1;
         cent_q <= 1'b0;
         date_q <= 6'h01;
         mon_q  <= 5'h01;
         year_q <= 8'h00;
         stop_q <= 1'b0;
      end else begin
         ctrl_q <= ctrl_n;
         sec_q  <= sec_n;
         min_q  <= min_n;
         hour_q <= hour_n;
         wday_q <= wday_n;
         cent_q <= cent_n;
         date_q <= date_n;
         mon_q  <= mon_n;
         year_q <= year_n;
         stop_q <= stop_n;
      end
   end

   always_comb begin
      case (fld)
         F_CTRL:  rd = ctrl_q;
         F_SEC:   rd = {stop_q, sec_q};
         F_MIN:   rd = {1'b0, min_q};
         F_HOUR:  rd = {2'b0, hour_q};
         F_WDAY:  rd = {1'b0, cent_q, 3'b000, wday_q};
         F_DATE:  rd = {2'b0, date_q};
         F_MON:   rd = {3'b0, mon_q};
         default: rd = year_q;
      endcase
   end

   assign stop_o = stop_q;
   assign sec_o  = sec_q;
endmodule

// File: rtl/bcd_rtc_nvram.sv
module bcd_rtc_nvram
   import rtc_pkg::*;
#(
   parameter int unsigned ADDR_W        = 13,
   parameter int unsigned MEM_BYTES     = 512,
   parameter bit          WINDOW_AS_RAM = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [7:0]        wdata,
   input  logic              rd_en,
   output logic [7:0]        rdata,
   input  logic              lock_load,
   input  logic [1:0]        lock_din
);
   localparam int unsigned IDX_W    = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1;
   localparam int unsigned WIN_BASE = (2 ** ADDR_W) - 16;

   if (ADDR_W < 7 || ADDR_W > 16) begin : g_bad_aw
      $error("ADDR_W out of supported range");
   end
   if (MEM_BYTES < LOCK_BASE + LOCK_REGIONS * LOCK_SPAN || MEM_BYTES > WIN_BASE) begin : g_bad_mem
      $error("MEM_BYTES must cover the lock regions and stay below the top window");
   end

   region_e    region, region_q;
   logic [1:0] lock_q;
   logic [7:0] ram_q, win_q, tk_rd, clk_q;
   logic       tk_stop;
   logic [6:0] tk_sec;

   always_ff @(posedge clk) begin
      if (!rst_n)         lock_q <= 2'b00;
      else if (lock_load) lock_q <= lock_din;
   end

   rtc_addr_dec #(
      .ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .WINDOW_AS_RAM(WINDOW_AS_RAM)
   ) u_dec (
      .addr(addr), .lock(lock_q), .region(region)
   );

   rtc_byte_store #(.DEPTH(MEM_BYTES)) u_ram (
      .clk(clk),
      .we (wr_en && (region == RG_RAM)),
      .re (rd_en && (region == RG_RAM)),
      .idx(addr[IDX_W-1:0]),
      .wd (wdata),
      .rq (ram_q)
   );

   if (WINDOW_AS_RAM) begin : g_winram
      rtc_byte_store #(.DEPTH(8)) u_win (
         .clk(clk),
         .we (wr_en && (region == RG_WINRAM)),
         .re (rd_en && (region == RG_WINRAM)),
         .idx(addr[2:0]),
         .wd (wdata),
         .rq (win_q)
      );
   end else begin : g_winrsv
      assign win_q = 8'h00;
   end

   rtc_timekeeper u_tk (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_1hz),
      .we    (wr_en && (region == RG_CLOCK)),
      .fsel  (addr[2:0]),
      .wd    (wdata),
      .rd    (tk_rd),
      .stop_o(tk_stop),
      .sec_o (tk_sec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         region_q <= RG_VOID;
         clk_q    <= 8'h00;
      end else if (rd_en) begin
         region_q <= region;
         clk_q    <= tk_rd;
      end
   end

   always_comb begin
      case (region_q)
         RG_RAM:    rdata = ram_q;
         RG_WINRAM: rdata = win_q;
         RG_CLOCK:  rdata = clk_q;
         RG_WINRSV: rdata = 8'h00;
         default:   rdata = 8'hFF;
      endcase
   end
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk #(
   parameter int unsigned ADDR_W    = 13,
   parameter int unsigned MEM_BYTES = 512
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic              rd_en,
   input logic [7:0]        rdata,
   input logic [1:0]        lock_q,
   input logic              tk_stop,
   input logic [6:0]        tk_sec
);
   localparam logic [ADDR_W-1:0] CLK0   = ADDR_W'((2 ** ADDR_W) - 8);
   localparam logic [ADDR_W-1:0] WIN0   = ADDR_W'((2 ** ADDR_W) - 16);
   localparam logic [ADDR_W-1:0] MEMTOP = ADDR_W'(MEM_BYTES);

   a_r4_ctrl_bits: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && addr == CLK0 |=> rdata[7] && !rdata[5] && rdata[4]);

   a_r6_sec_range: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && addr == CLK0 + 1 |=> rdata[6:0] <= 7'h59 && rdata[3:0] <= 4'd9);

   a_r8_month_range: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && addr == CLK0 + 6 |=> rdata >= 8'h01 && rdata <= 8'h12 && rdata[3:0] <= 4'd9);

   a_r3_void_ff: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && addr >= MEMTOP && addr < WIN0 |=> rdata == 8'hFF);

   a_r10_lock0_ff: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && lock_q[0] && addr >= 32 && addr < 48 |=> rdata == 8'hFF);

   a_r10_lock1_ff: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && lock_q[1] && addr >= 48 && addr < 64 |=> rdata == 8'hFF);

   a_r5_stop_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      tk_stop && !(wr_en && addr == CLK0 + 1) |=> $stable(tk_sec));
endmodule

bind bcd_rtc_nvram rtc_chk #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
   .rdata(rdata), .lock_q(lock_q), .tk_stop(tk_stop), .tk_sec(tk_sec)
);

// File: tb/sim_bcd_rtc_nvram.sv
`timescale 1ns/1ps
module sim_bcd_rtc_nvram;
   localparam logic [12:0] A_CTL = 13'h1FF8, A_SEC = 13'h1FF9, A_MIN = 13'h1FFA,
                           A_HR  = 13'h1FFB, A_WD  = 13'h1FFC, A_DT  = 13'h1FFD,
                           A_MO  = 13'h1FFE, A_YR  = 13'h1FFF;

   logic        clk = 0, rst_n = 0, tick = 0, wr_en = 0, rd_en = 0, lock_load = 0;
   logic [12:0] addr = '0;
   logic [7:0]  wdata = '0, rdata0, rdata1;
   logic [1:0]  lock_din = '0;
   int          n_tests = 0, n_fail = 0;
   bit          done = 0;

   always #5 clk = ~clk;

   bcd_rtc_nvram u0 (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .addr(addr), .wr_en(wr_en),
      .wdata(wdata), .rd_en(rd_en), .rdata(rdata0), .lock_load(lock_load), .lock_din(lock_din)
   );
   bcd_rtc_nvram #(.WINDOW_AS_RAM(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .addr(addr), .wr_en(wr_en),
      .wdata(wdata), .rd_en(rd_en), .rdata(rdata1), .lock_load(lock_load), .lock_din(lock_din)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [12:0] a, input logic [7:0] d, input bit with_tick = 0);
      @(negedge clk); addr = a; wdata = d; wr_en = 1; tick = with_tick;
      @(negedge clk); wr_en = 0; tick = 0;
   endtask

   task automatic rd(input logic [12:0] a, output logic [7:0] d0, output logic [7:0] d1);
      @(negedge clk); addr = a; rd_en = 1;
      @(negedge clk); rd_en = 0; d0 = rdata0; d1 = rdata1;
   endtask

   task automatic expect0(input string req, input logic [12:0] a, input logic [7:0] exp);
      logic [7:0] d0, d1;
      rd(a, d0, d1);
      chk(req, d0, exp);
   endtask

   task automatic pulse_tick();
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
   endtask

   task automatic set_locks(input logic [1:0] v);
      @(negedge clk); lock_din = v; lock_load = 1;
      @(negedge clk); lock_load = 0;
   endtask

   task automatic day_roll(input int n);
      for (int i = 0; i < n; i++) begin
         wr(A_HR, 8'h23); wr(A_MIN, 8'h59); wr(A_SEC, 8'h59);
         pulse_tick();
      end
   endtask

   task automatic t_reset();
      expect0("R1 sec", A_SEC, 8'h00);  expect0("R1 min", A_MIN, 8'h00);
      expect0("R1 hour", A_HR, 8'h00);  expect0("R1 wday", A_WD, 8'h01);
      expect0("R1 date", A_DT, 8'h01);  expect0("R1 month", A_MO, 8'h01);
      expect0("R1 year", A_YR, 8'h00);  expect0("R1 ctrl", A_CTL, 8'h90);
      wr(13'h005, 8'hA5);
      do_reset();
      expect0("R1 ram kept", 13'h005, 8'hA5);
   endtask

   task automatic t_ram();
      wr(13'h000, 8'h3C); wr(13'h0FF, 8'hC3); wr(13'h1FF, 8'h00);
      expect0("R2 ram 0", 13'h000, 8'h3C);
      expect0("R2 ram ff", 13'h0FF, 8'hC3);
      expect0("R2 ram top", 13'h1FF, 8'h00);
   endtask

   task automatic t_void();
      wr(13'h300, 8'h12); wr(13'h1FEF, 8'h34);
      expect0("R3 void", 13'h300, 8'hFF);
      expect0("R3 void edge", 13'h1FEF, 8'hFF);
      expect0("R3 mem edge", 13'h200, 8'hFF);
   endtask

   task automatic t_ctrl();
      wr(A_CTL, 8'hFF); expect0("R4 ff", A_CTL, 8'hDF);
      wr(A_CTL, 8'h00); expect0("R4 00", A_CTL, 8'h90);
      wr(A_CTL, 8'h2A); expect0("R4 2a", A_CTL, 8'h9A);
   endtask

   task automatic t_fields();
      wr(A_SEC, 8'h45); expect0("R6 sec ok", A_SEC, 8'h45);
      wr(A_SEC, 8'h60); expect0("R6 sec 60", A_SEC, 8'h45);
      wr(A_SEC, 8'h4A); expect0("R6 sec digit", A_SEC, 8'h45);
      wr(A_MIN, 8'hB3); expect0("R6 min mask", A_MIN, 8'h33);
      wr(A_HR, 8'h24);  expect0("R6 hour 24", A_HR, 8'h00);
      wr(A_HR, 8'hD2);  expect0("R6 hour mask", A_HR, 8'h12);
      wr(A_DT, 8'h00);  expect0("R6 date 0", A_DT, 8'h01);
      wr(A_DT, 8'hE7);  expect0("R6 date mask", A_DT, 8'h07);
      wr(A_MO, 8'h13);  expect0("R6 month 13", A_MO, 8'h01);
      wr(A_MO, 8'h00);  expect0("R6 month 0", A_MO, 8'h01);
      wr(A_MO, 8'h12);  expect0("R6 month 12", A_MO, 8'h12);
      wr(A_YR, 8'h9A);  expect0("R6 year digit", A_YR, 8'h00);
      wr(A_YR, 8'h99);  expect0("R6 year 99", A_YR, 8'h99);
   endtask

   task automatic t_carry();
      wr(A_YR, 8'h23); wr(A_MO, 8'h03); wr(A_DT, 8'h05);
      wr(A_SEC, 8'h09); pulse_tick(); expect0("R7 sec bcd", A_SEC, 8'h10);
      wr(A_HR, 8'h10); wr(A_MIN, 8'h59); wr(A_SEC, 8'h59); pulse_tick();
      expect0("R7 hour carry", A_HR, 8'h11); expect0("R7 min wrap", A_MIN, 8'h00);
      day_roll(1);
      expect0("R7 sec wrap", A_SEC, 8'h00); expect0("R7 hour wrap", A_HR, 8'h00);
      expect0("R7 date inc", A_DT, 8'h06);
   endtask

   task automatic t_stop();
      wr(A_SEC, 8'hB0);
      repeat (3) pulse_tick();
      expect0("R5 frozen", A_SEC, 8'hB0);
      wr(A_SEC, 8'h7F); expect0("R5 resume value", A_SEC, 8'h30);
      pulse_tick(); expect0("R5 counting", A_SEC, 8'h31);
   endtask

   task automatic t_calendar();
      wr(A_YR, 8'h24); wr(A_MO, 8'h02); wr(A_DT, 8'h19);
      day_roll(9); expect0("R8 leap 28", A_DT, 8'h28);
      day_roll(1); expect0("R8 leap 29", A_DT, 8'h29);
      day_roll(1); expect0("R8 leap wrap", A_DT, 8'h01); expect0("R8 leap mon", A_MO, 8'h03);
      wr(A_YR, 8'h23); wr(A_MO, 8'h02); wr(A_DT, 8'h19);
      day_roll(10); expect0("R8 feb wrap", A_DT, 8'h01); expect0("R8 feb mon", A_MO, 8'h03);
      wr(A_MO, 8'h04); wr(A_DT, 8'h19);
      day_roll(11); expect0("R8 apr 30", A_DT, 8'h30);
      day_roll(1);  expect0("R8 apr wrap", A_DT, 8'h01); expect0("R8 apr mon", A_MO, 8'h05);
      wr(A_YR, 8'h99); wr(A_MO, 8'h12); wr(A_DT, 8'h19);
      day_roll(12); expect0("R8 dec 31", A_DT, 8'h31);
      day_roll(1);
      expect0("R8 year date", A_DT, 8'h01); expect0("R8 year mon", A_MO, 8'h01);
      expect0("R8 year wrap", A_YR, 8'h00);
   endtask

   task automatic t_wday();
      wr(A_WD, 8'h45); expect0("R9 wday cent", A_WD, 8'h45);
      wr(A_WD, 8'hFF); expect0("R9 wday mask", A_WD, 8'h47);
      day_roll(1); expect0("R9 wday wrap", A_WD, 8'h41);
      day_roll(1); expect0("R9 wday inc", A_WD, 8'h42);
   endtask

   task automatic t_locks();
      wr(13'h025, 8'h11); wr(13'h035, 8'h22);
      set_locks(2'b01);
      expect0("R10 lock0 read", 13'h025, 8'hFF);
      expect0("R10 lock0 other", 13'h035, 8'h22);
      wr(13'h025, 8'h99);
      set_locks(2'b10);
      expect0("R10 lock0 write dropped", 13'h025, 8'h11);
      expect0("R10 lock1 read", 13'h035, 8'hFF);
      wr(13'h035, 8'h77);
      set_locks(2'b00);
      expect0("R10 lock1 write dropped", 13'h035, 8'h22);
      set_locks(2'b11);
      do_reset();
      expect0("R1 locks cleared", 13'h025, 8'h11);
   endtask

   task automatic t_window();
      logic [7:0] d0, d1;
      wr(13'h1FF3, 8'h5A); wr(13'h1FF0, 8'h3C);
      rd(13'h1FF3, d0, d1);
      chk("R11 reserved", d0, 8'h00); chk("R11 window ram", d1, 8'h5A);
      rd(13'h1FF0, d0, d1);
      chk("R11 reserved flags", d0, 8'h00); chk("R11 window ram 0", d1, 8'h3C);
   endtask

   task automatic t_same_cycle();
      wr(A_MIN, 8'h10); wr(A_SEC, 8'h59);
      wr(A_MIN, 8'h20, 1);
      expect0("R12 sec advanced", A_SEC, 8'h00);
      expect0("R12 min written", A_MIN, 8'h20);
      wr(A_SEC, 8'h15, 1);
      expect0("R12 sec written", A_SEC, 8'h15);
      expect0("R12 min unchanged", A_MIN, 8'h20);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_ram();
      t_void();
      t_ctrl();
      t_fields();
      t_carry();
      t_stop();
      t_calendar();
      t_wday();
      t_locks();
      t_window();
      t_same_cycle();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got hang expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule